// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block forms the signed product of two two's-complement operands. The multiplier operand is scanned in overlapping three-bit windows, and each window selects one signed multiple of the multiplicand: zero, plus or minus once, or plus or minus twice. Each multiple is sign-extended to double width and shifted by two bit positions per window. For eight-bit operands there are four such terms.

The terms are folded by a chain of carry-save rows into one sum vector and one carry vector. A carry-lookahead adder built from four-bit groups then adds the two vectors. Negative multiples are formed as an inverted word. The missing +1 of each negative multiple goes into a separate correction word, which joins the carry-save chain as one more operand.

Both operands are captured in registers on a rising clock edge. The product register loads on the next edge, so the block accepts a fresh operand pair on every cycle. A synchronous active-high reset clears all three registers. The operand width is a parameter (even, at least 4) with a default of 8.

Top module: `booth_mult_top`

## Requirements
- R1: While `rst` is high at a rising edge, the operand and product registers load zero. `prod_o` reads zero after that edge and also after the first edge with `rst` low.
- R2: `prod_o` equals the signed product of `mplr_i` and `mcnd_i` as a 2W-bit two's-complement value. It appears after the second rising edge following the cycle in which the pair is presented.
- R3: A new operand pair may be presented on every cycle. Each product depends only on its own pair, with no interference from the pairs before or after it.
- R4: A zero operand gives a zero product. A multiplier of all ones (value -1, where every window except the lowest reads 111 and selects zero) gives the negated multiplicand.
- R5: Multiplier values whose windows select +2 or -2 times the multiplicand (windows 011 and 100, bits ordered high, middle, low with a zero below bit 0) give the exact product.
- R6: The operand extremes give exact results: min×min = 16384, min×max = -16256 and max×max = 16129 for W = 8.
- R7: A multiplicand at the most negative value gives the exact product under negative selections, including the doubled negative multiple.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mplr_i | input | W | Signed multiplier operand (Booth-recoded) |
| mcnd_i | input | W | Signed multiplicand operand |
| prod_o | output | 2W | Registered signed product |

## Verification
Reset and an operand capture can fall on the same edge. So can reset and the product update of a pair captured one edge earlier. The bench provokes both by raising `rst` while a valid pair is already in the operand registers and a new pair sits on the inputs. It then releases reset with that new pair still applied. The product must read zero after the reset edge and stay zero after the release edge, because the operand registers were cleared. The new pair's product must then show up one edge later.

// File: rtl/booth_mult_pkg.sv
package booth_mult_pkg;

    typedef enum logic [2:0] {
        SEL_ZERO,
        SEL_POS1,
        SEL_POS2,
        SEL_NEG1,
        SEL_NEG2
    } booth_sel_e;

    // Window bits are {upper, middle, lower}; lower is the bit below the pair.
    function automatic booth_sel_e booth_decode(input logic [2:0] trio);
        booth_sel_e sel;
        case (trio)
            3'b001, 3'b010: sel = SEL_POS1;
            3'b011:         sel = SEL_POS2;
            3'b100:         sel = SEL_NEG2;
            3'b101, 3'b110: sel = SEL_NEG1;
            default:        sel = SEL_ZERO;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/booth_pp_gen.sv
module booth_pp_gen #(
    parameter int W     = 8,
    parameter int PW    = 2 * W,
    parameter int SHIFT = 0
) (
    input  logic [2:0]    trio,
    input  logic [W-1:0]  mcnd,
    output logic [PW-1:0] pp,
    output logic          neg
);
    import booth_mult_pkg::*;

    booth_sel_e    sel;
    logic [PW-1:0] ext;
    logic [PW-1:0] mag;
    logic [PW-1:0] body;

    always_comb begin
        sel = booth_decode(trio);
        ext = PW'(signed'(mcnd));
        case (sel)
            SEL_POS1, SEL_NEG1: mag = ext;
            SEL_POS2, SEL_NEG2: mag = ext << 1;
            default:            mag = '0;
        endcase
        neg  = (sel == SEL_NEG1) || (sel == SEL_NEG2);
        // The +1 that completes the negation is supplied by the correction word.
        body = neg ? ~mag : mag;
        pp   = body << SHIFT;
    end

endmodule

// File: rtl/csa_row.sv
module csa_row #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] in_a,
    input  logic [PW-1:0] in_b,
    input  logic [PW-1:0] in_c,
    output logic [PW-1:0] sum_o,
    output logic [PW-1:0] cy_o
);
    logic [PW-1:0] maj;

    assign sum_o = in_a ^ in_b ^ in_c;
    assign maj   = (in_a & in_b) | (in_a & in_c) | (in_b & in_c);
    // Carry word is pre-aligned; the bit leaving the top is dropped.
    assign cy_o  = {maj[PW-2:0], 1'b0};

endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
    parameter int PW = 16,
    parameter int GW = 4
) (
    input  logic [PW-1:0] op_a,
    input  logic [PW-1:0] op_b,
    output logic [PW-1:0] sum_o
);
    localparam int NG = PW / GW;

    logic [PW-1:0] bp;
    logic [PW-1:0] bg;
    logic [PW-1:0] cin;
    logic [NG-1:0] grp_g;
    logic [NG-1:0] grp_p;
    logic [NG:0]   grp_c;

    always_comb begin
        logic acc_g;
        logic acc_p;
        logic run;
        bp = op_a ^ op_b;
        bg = op_a & op_b;
        // group generate / propagate
        for (int j = 0; j < NG; j++) begin
            acc_g = 1'b0;
            acc_p = 1'b1;
            for (int k = 0; k < GW; k++) begin
                acc_g = bg[j*GW+k] | (bp[j*GW+k] & acc_g);
                acc_p = acc_p & bp[j*GW+k];
            end
            grp_g[j] = acc_g;
            grp_p[j] = acc_p;
        end
        // carries into each group
        grp_c[0] = 1'b0;
        for (int j = 0; j < NG; j++) begin
            grp_c[j+1] = grp_g[j] | (grp_p[j] & grp_c[j]);
        end
        // carries inside each group from the group carry-in
        for (int j = 0; j < NG; j++) begin
            for (int k = 0; k < GW; k++) begin
                run = grp_c[j];
                for (int m = 0; m < k; m++) begin
                    run = bg[j*GW+m] | (bp[j*GW+m] & run);
                end
                cin[j*GW+k] = run;
            end
        end
        sum_o = bp ^ cin;
    end

endmodule

// File: rtl/booth_mult_top.sv
module booth_mult_top #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   mplr_i,
    input  logic [W-1:0]   mcnd_i,
    output logic [2*W-1:0] prod_o
);
    localparam int PW   = 2 * W;
    localparam int NPP  = (W + 1) / 2;
    localparam int XW   = 2 * NPP;
    localparam int NOPS = NPP + 1;
    localparam int NROW = NOPS - 2;
    localparam int GW   = 4;

    typedef struct packed {
        logic [W-1:0]  x;
        logic [W-1:0]  y;
        logic [PW-1:0] p;
    } mul_state_t;

    mul_state_t st_d;
    mul_state_t st_q;

    logic [XW-1:0]  x_ext;
    logic [XW:0]    x_win;
    logic [NPP-1:0] neg_v;
    logic [PW-1:0]  corr_w;
    logic [PW-1:0]  pp_w [NPP];
    logic [PW-1:0]  row_s [NROW];
    logic [PW-1:0]  row_c [NROW];
    logic [PW-1:0]  sum_w;

    assign x_ext = XW'(signed'(st_q.x));
    assign x_win = {x_ext, 1'b0};

    for (genvar i = 0; i < NPP; i++) begin : g_pp
        booth_pp_gen #(
            .W    (W),
            .PW   (PW),
            .SHIFT(2 * i)
        ) u_pp (
            .trio(x_win[2*i+2:2*i]),
            .mcnd(st_q.y),
            .pp  (pp_w[i]),
            .neg (neg_v[i])
        );
    end

    always_comb begin
        corr_w = '0;
        for (int i = 0; i < NPP; i++) begin
            corr_w[2*i] = neg_v[i];
        end
    end

    for (genvar r = 0; r < NROW; r++) begin : g_row
        if (r == 0) begin : g_first
            csa_row #(.PW(PW)) u_csa (
                .in_a (pp_w[0]),
                .in_b (pp_w[1]),
                .in_c ((NPP > 2) ? pp_w[NPP > 2 ? 2 : 0] : corr_w),
                .sum_o(row_s[r]),
                .cy_o (row_c[r])
            );
        end else begin : g_next
            csa_row #(.PW(PW)) u_csa (
                .in_a (row_s[r-1]),
                .in_b (row_c[r-1]),
                .in_c ((r + 2 < NPP) ? pp_w[(r + 2 < NPP) ? r + 2 : 0] : corr_w),
                .sum_o(row_s[r]),
                .cy_o (row_c[r])
            );
        end
    end

    cla_adder #(
        .PW(PW),
        .GW(GW)
    ) u_cla (
        .op_a (row_s[NROW-1]),
        .op_b (row_c[NROW-1]),
        .sum_o(sum_w)
    );

    always_comb begin
        st_d   = st_q;
        st_d.x = mplr_i;
        st_d.y = mcnd_i;
        st_d.p = sum_w;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign prod_o = st_q.p;

endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst,
    input logic [W-1:0]   mplr_i,
    input logic [W-1:0]   mcnd_i,
    input logic [2*W-1:0] prod_o
);
    localparam int PW = 2 * W;
    localparam logic [W-1:0]  MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic [PW-1:0] MINSQ = PW'(1) << (PW - 2);

    logic [1:0]   age_q;
    logic [W-1:0] x_h1, x_h2, y_h1, y_h2;
    logic signed [PW-1:0] xs, ys, ref_p;

    always_ff @(posedge clk) begin
        if (rst) age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
        x_h1 <= mplr_i;
        x_h2 <= x_h1;
        y_h1 <= mcnd_i;
        y_h2 <= y_h1;
    end

    assign xs    = PW'(signed'(x_h2));
    assign ys    = PW'(signed'(y_h2));
    assign ref_p = xs * ys;

    AST_RST_CLEAR: assert property (@(posedge clk) rst |=> prod_o == '0); // R1
    AST_PRODUCT: assert property (@(posedge clk) disable iff (rst)
        age_q == 2'd2 |-> prod_o == ref_p); // R2
    AST_ZERO_OPND: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2 && (x_h2 == '0 || y_h2 == '0)) |-> prod_o == '0); // R4
    AST_SIGN: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2 && x_h2 != '0 && y_h2 != '0)
        |-> prod_o[PW-1] == (x_h2[W-1] ^ y_h2[W-1])); // R2
    AST_MIN_SQUARE: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2 && x_h2 == MINV && y_h2 == MINV) |-> prod_o == MINSQ); // R6

endmodule

bind booth_mult_top booth_mult_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .mplr_i(mplr_i),
    .mcnd_i(mcnd_i),
    .prod_o(prod_o)
);

// File: tb/booth_mult_top_tb_top.sv
module booth_mult_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int NV = 16;

    // each entry: {multiplier, multiplicand}
    localparam logic [15:0] VEC [NV] = '{
        16'h005B, 16'h3700, 16'hFF2D, 16'hFFFF,   // R4
        16'h0211, 16'hFE11, 16'h66C3, 16'h9A3C,   // R5
        16'h8080, 16'h807F, 16'h7F80, 16'h7F7F,   // R6
        16'hFF80, 16'hFE80, 16'h0380, 16'h5580    // R7
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [W-1:0]   mplr = '0;
    logic [W-1:0]   mcnd = '0;
    logic [2*W-1:0] prod;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    booth_mult_top #(.W(W)) dut_i (
        .clk   (clk),
        .rst   (rst),
        .mplr_i(mplr),
        .mcnd_i(mcnd),
        .prod_o(prod)
    );

    function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic signed [15:0] sa, sb;
        sa = 16'(signed'(a));
        sb = 16'(signed'(b));
        return sa * sb;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        logic [15:0] e1, e2;
        string tag;
        // R1: reset with nonzero inputs
        mplr = 8'h5A;
        mcnd = 8'h33;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 under reset", prod, 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        check("R1 first edge after release", prod, 16'h0000);
        @(negedge clk);
        check("R2 first product", prod, ref_mul(8'h5A, 8'h33));

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            mplr = VEC[i][15:8];
            mcnd = VEC[i][7:0];
            @(negedge clk);
            @(negedge clk);
            case (i / 4)
                0: tag = "R4 table";
                1: tag = "R5 table";
                2: tag = "R6 table";
                default: tag = "R7 table";
            endcase
            check(tag, prod, ref_mul(VEC[i][15:8], VEC[i][7:0]));
        end

        // R3: exhaustive back-to-back stream
        e1 = '0;
        e2 = '0;
        for (int i = 0; i < 65536 + 2; i++) begin
            @(negedge clk);
            if (i >= 2) check("R3 stream", prod, e2);
            e2 = e1;
            if (i < 65536) begin
                mplr = 8'(i >> 8);
                mcnd = 8'(i);
            end
            e1 = ref_mul(mplr, mcnd);
        end

        // R1: reset colliding with capture and product update
        @(negedge clk);
        mplr = 8'h7F;
        mcnd = 8'h7F;
        @(negedge clk);
        mplr = 8'h12;
        mcnd = 8'h34;
        rst  = 1'b1;
        @(negedge clk);
        check("R1 reset over pending product", prod, 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        check("R1 cleared operands after release", prod, 16'h0000);
        @(negedge clk);
        check("R2 product after mid-stream reset", prod, ref_mul(8'h12, 8'h34));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule